// File: doc/BRIEF.md
# Dual-Port Per-Bank Access Arbiter

This block sits between two independent 32-bit bus ports and three memory banks. Each port presents a request level together with a bank index and an address. Arbitration is kept separately for each bank. Two ports that address different idle banks are both admitted in the same cycle. Two ports that address the same idle bank are ordered by a selectable policy, and the loser waits.

A grant is a one-cycle pulse that admits one access. From the next cycle the bank sees a request and a port select. It also sees the address that the admitted port presented when it was granted. The bank keeps this ownership until it raises its done input. A port that has been granted may present its next request in the following cycle.

The policy input can be changed at any time. It is only consulted when an idle bank makes a decision, so a change never alters an access that is already running.

Top module: `dual_port_bank_arbiter`

## Requirements
- R1: While `rst` is high no port is granted and every `bank_req` bit is low from the first clock edge on. At reset each bank's round-robin history points at port 1.
- R2: When both ports request different banks, with each index below the bank count, and both banks are idle, both `p_gnt` bits are high in that same cycle.
- R3: No bank is ever granted to both ports in one cycle.
- R4: With `arb_mode` = 0 (fixed priority), port 0 wins whenever both ports request the same idle bank.
- R5: With `arb_mode` = 1 (round robin), a contended idle bank grants the port that did not win its previous contended decision. Every contended decision records its winner per bank, in either mode; uncontended grants leave that record unchanged.
- R6: A grant to port p for bank b in cycle t makes `bank_req[b]` high from cycle t+1. In that cycle `bank_sel[b]` equals p (0 or 1) and `bank_addr[b]` equals the address port p drove in cycle t. The three outputs hold until `bank_done[b]` is sampled high, and `bank_req[b]` is low in the cycle after that.
- R7: A bank with `bank_req` high grants no port. A port waiting on it is granted in the first cycle that `bank_req` is low again.
- R8: Changing `arb_mode` while a bank is owned does not change that bank's `bank_sel` or `bank_addr`. The new mode applies at the bank's next decision.
- R9: A request whose bank index is at or above the bank count (code 3 with three banks) is never granted, and its `p_wait` stays high.
- R10: `bank_done` on an idle bank is ignored. `bank_req` stays low, and the next decision on that bank behaves as if no done had arrived.
- R11: `p_wait[p]` is high exactly when port p requests and is not granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_mode | input | 1 | 0 = fixed priority (port 0 first), 1 = round robin |
| p_req | input | 2 | Request level per port |
| p_bank | input | 2x2 | Bank index per port |
| p_addr | input | 2x32 | Address per port |
| p_gnt | output | 2 | One-cycle admission pulse per port |
| p_wait | output | 2 | Port requesting but not admitted this cycle |
| bank_req | output | 3 | Bank owned by an admitted access |
| bank_sel | output | 3 | Owning port per bank |
| bank_addr | output | 3x32 | Captured address per bank |
| bank_done | input | 3 | Bank finished its access |

## Verification
The bench builds the block with its defaults: three banks and 32-bit addresses. With three banks the 2-bit index has one spare code, 3, so the out-of-range path is reachable. Every bank pair is also reachable, which covers both the concurrent case and the contended case. A behavioural model of per-bank ownership and round-robin history is checked against the outputs on every clock. Directed sequences drive mode switches during ownership and done pulses on idle banks, and a long pseudo-random phase follows them.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    localparam int NPORT = 2;

    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_ROUND = 1'b1
    } arb_mode_e;

    typedef logic port_id_t;

    typedef struct packed {
        logic     busy;
        port_id_t owner;
        port_id_t last;
    } slot_state_t;

    // Winner among requesting ports; valid only when hit is non-zero.
    function automatic port_id_t pick_port(input logic [NPORT-1:0] hit,
                                           input arb_mode_e       mode,
                                           input port_id_t        last);
        if (&hit) begin
            return (mode == ARB_ROUND) ? ~last : 1'b0;
        end
        return hit[1];
    endfunction

endpackage

// File: rtl/dpa_req_decode.sv
module dpa_req_decode
    import dpa_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BIDX_W    = 2
) (
    input  logic [NPORT-1:0]                          p_req,
    input  logic [NPORT-1:0][BIDX_W-1:0]              p_bank,
    output logic [NUM_BANKS-1:0][NPORT-1:0]           hit
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            assign hit[b][p] = p_req[p] && (p_bank[p] == BIDX_W'(b));
        end
    end

endmodule

// File: rtl/dpa_bank_slot.sv
module dpa_bank_slot
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  arb_mode_e                     mode,
    input  logic [NPORT-1:0]              hit,
    input  logic [NPORT-1:0][ADDR_W-1:0]  p_addr,
    input  logic                          done,
    output logic [NPORT-1:0]              grant,
    output logic                          busy,
    output port_id_t                      owner,
    output logic [ADDR_W-1:0]             addr_q
);

    slot_state_t st;
    logic        free;
    port_id_t    win;

    always_comb begin
        free  = !st.busy && !rst;
        win   = pick_port(hit, mode, st.last);
        grant = '0;
        if (free && (|hit)) begin
            grant[win] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '{busy: 1'b0, owner: 1'b0, last: 1'b1};
            addr_q <= '0;
        end else if (st.busy) begin
            if (done) begin
                st.busy <= 1'b0;
            end
        end else if (|hit) begin
            st.busy  <= 1'b1;
            st.owner <= win;
            addr_q   <= p_addr[win];
            if (&hit) begin
                st.last <= win;
            end
        end
    end

    assign busy  = st.busy;
    assign owner = st.owner;

endmodule

// File: rtl/dpa_grant_collect.sv
module dpa_grant_collect
    import dpa_pkg::*;
#(
    parameter int NUM_BANKS = 3
) (
    input  logic [NUM_BANKS-1:0][NPORT-1:0] bank_grant,
    input  logic [NPORT-1:0]                p_req,
    output logic [NPORT-1:0]                p_gnt,
    output logic [NPORT-1:0]                p_wait
);

    always_comb begin
        p_gnt = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            p_gnt = p_gnt | bank_grant[b];
        end
        p_wait = p_req & ~p_gnt;
    end

endmodule

// File: rtl/dual_port_bank_arbiter.sv
module dual_port_bank_arbiter
    import dpa_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 32,
    parameter int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              arb_mode,
    input  logic [NPORT-1:0]                  p_req,
    input  logic [NPORT-1:0][BIDX_W-1:0]      p_bank,
    input  logic [NPORT-1:0][ADDR_W-1:0]      p_addr,
    output logic [NPORT-1:0]                  p_gnt,
    output logic [NPORT-1:0]                  p_wait,
    output logic [NUM_BANKS-1:0]              bank_req,
    output logic [NUM_BANKS-1:0]              bank_sel,
    output logic [NUM_BANKS-1:0][ADDR_W-1:0]  bank_addr,
    input  logic [NUM_BANKS-1:0]              bank_done
);

    arb_mode_e                       mode;
    logic [NUM_BANKS-1:0][NPORT-1:0] hit;
    logic [NUM_BANKS-1:0][NPORT-1:0] bgrant;

    assign mode = arb_mode_e'(arb_mode);

    dpa_req_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BIDX_W    (BIDX_W)
    ) u_decode (
        .p_req  (p_req),
        .p_bank (p_bank),
        .hit    (hit)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
        dpa_bank_slot #(
            .ADDR_W (ADDR_W)
        ) u_slot (
            .clk    (clk),
            .rst    (rst),
            .mode   (mode),
            .hit    (hit[b]),
            .p_addr (p_addr),
            .done   (bank_done[b]),
            .grant  (bgrant[b]),
            .busy   (bank_req[b]),
            .owner  (bank_sel[b]),
            .addr_q (bank_addr[b])
        );
    end

    dpa_grant_collect #(
        .NUM_BANKS (NUM_BANKS)
    ) u_collect (
        .bank_grant (bgrant),
        .p_req      (p_req),
        .p_gnt      (p_gnt),
        .p_wait     (p_wait)
    );

endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 32,
    parameter int BIDX_W    = 2
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              arb_mode,
    input logic [1:0]                        p_req,
    input logic [1:0][BIDX_W-1:0]            p_bank,
    input logic [1:0][ADDR_W-1:0]            p_addr,
    input logic [1:0]                        p_gnt,
    input logic [1:0]                        p_wait,
    input logic [NUM_BANKS-1:0]              bank_req,
    input logic [NUM_BANKS-1:0]              bank_sel,
    input logic [NUM_BANKS-1:0][ADDR_W-1:0]  bank_addr,
    input logic [NUM_BANKS-1:0]              bank_done
);

    p_reset_gnt_r1: assert property (@(posedge clk) rst |-> (p_gnt == 2'b00));
    p_reset_bank_r1: assert property (@(posedge clk) rst |=> (bank_req == '0));

    p_single_r3: assert property (@(posedge clk) disable iff (rst)
        !(p_gnt[0] && p_gnt[1] && (p_bank[0] == p_bank[1])));

    p_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        ((arb_mode == 1'b0) && p_req[0] && p_req[1] && (p_bank[0] == p_bank[1]))
        |-> !p_gnt[1]);

    for (genvar b0 = 0; b0 < NUM_BANKS; b0++) begin : g_pair
        for (genvar b1 = 0; b1 < NUM_BANKS; b1++) begin : g_other
            if (b0 != b1) begin : g_diff
                p_concurrent_r2: assert property (@(posedge clk) disable iff (rst)
                    (p_req[0] && p_req[1] && (p_bank[0] == BIDX_W'(b0))
                     && (p_bank[1] == BIDX_W'(b1)) && !bank_req[b0] && !bank_req[b1])
                    |-> (p_gnt == 2'b11));
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Ownership is held across mode changes as well (R8).
        p_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (bank_req[b] && !bank_done[b])
            |=> (bank_req[b] && $stable(bank_sel[b]) && $stable(bank_addr[b])));

        p_release_r6: assert property (@(posedge clk) disable iff (rst)
            (bank_req[b] && bank_done[b]) |=> !bank_req[b]);

        for (genvar p = 0; p < 2; p++) begin : g_port
            p_start_r6: assert property (@(posedge clk) disable iff (rst)
                (p_gnt[p] && (p_bank[p] == BIDX_W'(b)))
                |=> (bank_req[b] && (bank_sel[b] == 1'(p))
                     && (bank_addr[b] == $past(p_addr[p]))));

            p_busy_block_r7: assert property (@(posedge clk) disable iff (rst)
                bank_req[b] |-> !(p_gnt[p] && (p_bank[p] == BIDX_W'(b))));
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_oob
        p_oob_r9: assert property (@(posedge clk) disable iff (rst)
            (p_req[p] && (int'(p_bank[p]) >= NUM_BANKS)) |-> (!p_gnt[p] && p_wait[p]));
    end

endmodule

bind dual_port_bank_arbiter dpa_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .BIDX_W    (BIDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .arb_mode  (arb_mode),
    .p_req     (p_req),
    .p_bank    (p_bank),
    .p_addr    (p_addr),
    .p_gnt     (p_gnt),
    .p_wait    (p_wait),
    .bank_req  (bank_req),
    .bank_sel  (bank_sel),
    .bank_addr (bank_addr),
    .bank_done (bank_done)
);

// File: tb/sim_dual_port_bank_arbiter.sv
module sim_dual_port_bank_arbiter;

    localparam int NB = 3;
    localparam int BW = 2;
    localparam int AW = 32;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 arb_mode = 1'b0;
    logic [1:0]           p_req = '0;
    logic [1:0][BW-1:0]   p_bank = '0;
    logic [1:0][AW-1:0]   p_addr = '0;
    logic [NB-1:0]        bank_done = '0;
    logic [1:0]           p_gnt;
    logic [1:0]           p_wait;
    logic [NB-1:0]        bank_req;
    logic [NB-1:0]        bank_sel;
    logic [NB-1:0][AW-1:0] bank_addr;

    always #4 clk = ~clk;

    dual_port_bank_arbiter #(.NUM_BANKS(NB), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .arb_mode(arb_mode), .p_req(p_req), .p_bank(p_bank),
        .p_addr(p_addr), .p_gnt(p_gnt), .p_wait(p_wait), .bank_req(bank_req),
        .bank_sel(bank_sel), .bank_addr(bank_addr), .bank_done(bank_done)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // Behavioural reference state
    bit            mb_busy [NB];
    bit            mb_own  [NB];
    bit            mb_last [NB];
    logic [AW-1:0] mb_addr [NB];
    bit            eg [2];

    task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit r0, int b0, logic [AW-1:0] a0,
                        bit r1, int b1, logic [AW-1:0] a1,
                        bit m, logic [NB-1:0] dn, bit rs = 0);
        bit take [NB];
        bit win  [NB];
        bit both [NB];
        bit rq [2];
        int bk [2];
        string t;
        @(negedge clk);
        rst = rs; arb_mode = m; bank_done = dn;
        p_req = {r1, r0};
        p_bank[0] = BW'(b0); p_bank[1] = BW'(b1);
        p_addr[0] = a0; p_addr[1] = a1;
        #1;
        rq[0] = r0; rq[1] = r1; bk[0] = b0; bk[1] = b1;
        eg[0] = 0; eg[1] = 0;
        for (int b = 0; b < NB; b++) begin
            bit c0, c1;
            c0 = r0 && (b0 == b);
            c1 = r1 && (b1 == b);
            both[b] = c0 && c1;
            take[b] = 0;
            win[b] = 0;
            if (!rs && !mb_busy[b] && (c0 || c1)) begin
                take[b] = 1;
                if (c0 && c1) win[b] = m ? !mb_last[b] : 1'b0;
                else win[b] = c1;
                eg[win[b]] = 1;
            end
        end
        for (int p = 0; p < 2; p++) begin
            if (rs) t = "R1";
            else if (bk[p] >= NB) t = "R9";
            else if (mb_busy[bk[p]]) t = "R7";
            else if (r0 && r1 && b0 == b1) t = m ? "R5" : "R4";
            else t = "R2";
            chk(t, $sformatf("p_gnt[%0d]", p), AW'(p_gnt[p]), AW'(eg[p]));
            chk("R11", $sformatf("p_wait[%0d]", p), AW'(p_wait[p]), AW'(rq[p] && !eg[p]));
        end
        chk("R3", "double grant same bank",
            AW'(p_gnt[0] && p_gnt[1] && p_bank[0] == p_bank[1]), '0);
        for (int b = 0; b < NB; b++) begin
            chk(rs ? "R1" : "R6", $sformatf("bank_req[%0d]", b), AW'(bank_req[b]), AW'(mb_busy[b]));
            if (mb_busy[b] && !rs) begin
                chk("R6", $sformatf("bank_sel[%0d]", b), AW'(bank_sel[b]), AW'(mb_own[b]));
                chk("R6", $sformatf("bank_addr[%0d]", b), bank_addr[b], mb_addr[b]);
            end
        end
        for (int b = 0; b < NB; b++) begin
            if (rs) begin
                mb_busy[b] = 0; mb_own[b] = 0; mb_last[b] = 1; mb_addr[b] = '0;
            end else if (mb_busy[b]) begin
                if (dn[b]) mb_busy[b] = 0;
            end else if (take[b]) begin
                mb_busy[b] = 1;
                mb_own[b]  = win[b];
                mb_addr[b] = win[b] ? a1 : a0;
                if (both[b]) mb_last[b] = win[b];
            end
        end
    endtask

    task automatic idle(bit m, logic [NB-1:0] dn);
        step(0, 0, '0, 0, 0, '0, m, dn);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        bit rq [2];
        int bk [2];
        logic [AW-1:0] ad [2];
        bit m;
        logic [NB-1:0] dn;

        // R1: reset with a pending request
        for (int i = 0; i < 3; i++) step(1, 0, 32'h10, 1, 1, 32'h20, 0, '0, 1);

        // R2: different banks, same cycle
        step(1, 0, 32'hA000_0000, 1, 1, 32'hA111_1111, 0, '0);
        chk("R2", "both granted", AW'(p_gnt), 32'h3);
        idle(0, '0);
        idle(0, 3'b011);
        idle(0, '0);
        chk("R6", "banks released", AW'(bank_req), 32'h0);

        // R4 fixed priority contention on bank 2, then R7 waiting
        step(1, 2, 32'hB000_0000, 1, 2, 32'hB111_1111, 0, '0);
        chk("R4", "fixed winner", AW'(p_gnt), 32'h1);
        step(0, 0, '0, 1, 2, 32'hB111_1111, 0, '0);
        step(0, 0, '0, 1, 2, 32'hB111_1111, 0, '0);
        chk("R7", "loser waits", AW'(p_wait[1]), 32'h1);
        step(0, 0, '0, 1, 2, 32'hB111_1111, 0, 3'b100);
        step(0, 0, '0, 1, 2, 32'hB111_1111, 0, '0);
        chk("R7", "loser granted after done", AW'(p_gnt[1]), 32'h1);
        idle(0, '0);
        chk("R6", "owner port 1 address", bank_addr[2], 32'hB111_1111);
        idle(0, 3'b100);

        // R5 round robin: last winner on bank 2 was port 0
        step(1, 2, 32'hC000_0000, 1, 2, 32'hC111_1111, 1, '0);
        chk("R5", "rr winner port1", AW'(p_gnt), 32'h2);
        step(1, 2, 32'hC000_0000, 0, 0, '0, 1, '0);
        // R8: switch mode during ownership
        step(1, 2, 32'hC000_0000, 0, 0, '0, 0, '0);
        chk("R8", "sel kept", AW'(bank_sel[2]), 32'h1);
        chk("R8", "addr kept", bank_addr[2], 32'hC111_1111);
        step(1, 2, 32'hC000_0000, 0, 0, '0, 0, 3'b100);
        step(1, 2, 32'hC000_0000, 0, 0, '0, 0, '0);
        chk("R8", "next decision uses new mode", AW'(p_gnt), 32'h1);
        idle(1, 3'b100);
        step(1, 2, 32'hD000_0000, 1, 2, 32'hD111_1111, 1, '0);
        chk("R5", "rr winner port0", AW'(p_gnt), 32'h1);
        step(0, 0, '0, 1, 2, 32'hD111_1111, 1, 3'b100);
        step(0, 0, '0, 1, 2, 32'hD111_1111, 1, '0);
        idle(1, 3'b100);

        // R9 out-of-range bank index
        for (int i = 0; i < 3; i++) begin
            step(1, 3, 32'hE000_0000, 0, 0, '0, 1, '0);
            chk("R9", "oob never granted", AW'(p_gnt[0]), 32'h0);
            chk("R9", "oob waits", AW'(p_wait[0]), 32'h1);
        end

        // R10 done on idle banks
        idle(1, 3'b111);
        idle(1, '0);
        chk("R10", "idle done keeps bank free", AW'(bank_req), 32'h0);
        step(1, 1, 32'hF000_0000, 1, 1, 32'hF111_1111, 1, '0);
        chk("R10", "first rr decision unchanged", AW'(p_gnt), 32'h1);
        idle(1, 3'b010);

        // Pseudo-random phase
        m = 0;
        for (int p = 0; p < 2; p++) begin rq[p] = 0; bk[p] = 0; ad[p] = '0; end
        for (int i = 0; i < 4000; i++) begin
            for (int b = 0; b < NB; b++) dn[b] = ($urandom % 3) == 0;
            if (($urandom % 50) == 0) m = !m;
            step(rq[0], bk[0], ad[0], rq[1], bk[1], ad[1], m, dn);
            for (int p = 0; p < 2; p++) begin
                if (!rq[p] || eg[p] || bk[p] >= NB) begin
                    rq[p] = ($urandom % 4) != 0;
                    bk[p] = $urandom % 4;
                    ad[p] = $urandom;
                end
            end
        end

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule